// File: doc/BRIEF.md
# Paged Address Translation Unit

This block sits between a CPU and its main memory. It turns logical addresses in the low RAM zone into physical addresses by looking them up in a page table of 1024 sixteen-bit entries. Each page is 4 KiB. The translation is combinational, so the physical address is available in the same cycle as the access. Addresses at or above the top of the RAM zone leave the block unchanged.

On every translated access to a present page, the block rewrites the two-bit status field of the entry it used. A first read marks the page as read, and any write marks it dirty. The write-enable bit and the frame number of the entry are left as they were. Software loads and inspects the table through a separate port that decodes a fixed 64 KiB window. That port accepts whole 16-bit words or single bytes.

Top module: `pgmap_unit`

## Requirements
- R1: An access address at or above 0x400000 appears on `phys_addr` unchanged.
- R2: For an access address below 0x400000, `phys_addr` is combinational in the same cycle and equals {2'b00, entry[9:0], addr[11:0]}, where the entry index is addr[21:12].
- R3: A table-port word write (`tbl_byte`=0) stores `tbl_wdata` whole. A byte write stores `tbl_wdata[7:0]` into one byte only: bits 15:8 when `tbl_addr[0]`=0, and bits 7:0 when `tbl_addr[0]`=1.
- R4: A table-port write takes effect only when `tbl_addr[23:16]` is 0x40. The entry index is `tbl_addr[10:1]`, so addresses in the window repeat every 2 KiB. A write with any other upper byte changes no entry.
- R5: Status is held in entry bits 14:13 (0 absent, 1 clean, 2 read, 3 dirty). A read access to a clean page sets the status to 2, and a write access sets it to 3. Either change is visible on the read port in the next cycle.
- R6: On a page whose status is 2 or 3, a write access sets the status to 3 and a read access leaves it unchanged.
- R7: An access to a page whose status is 0 leaves its entry unchanged.
- R8: A status update never changes entry bit 15 (write enable) or bits 12:0.
- R9: If a table-port write and a status update hit the same entry in the same cycle, the entry takes the table-port value.
- R10: After reset, every entry reads as 0.
- R11: `tbl_rdata` shows, combinationally, the current entry at index `tbl_addr[10:1]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| acc_valid | input | 1 | CPU access takes place this cycle |
| acc_write | input | 1 | The access is a write (1) or a read (0) |
| acc_addr | input | 24 | CPU logical address |
| tbl_wr | input | 1 | Table-port write strobe |
| tbl_byte | input | 1 | Table-port write is one byte (1) or a whole word (0) |
| tbl_addr | input | 24 | Table-port address; also selects the entry shown on `tbl_rdata` |
| tbl_wdata | input | 16 | Table-port write data |
| phys_addr | output | 24 | Translated or passed-through address |
| tbl_rdata | output | 16 | Entry selected by `tbl_addr` |

## Verification
A CPU access that updates a status field and a table-port write can land on the same entry in the same clock edge. The bench forces this overlap in a directed case. It also provokes it often in the random phase by drawing both indices from a pool of only eight pages. After each such edge the entry is read back through `tbl_rdata` and compared with a model in which the port write overrides the status update. The byte-merge case is also covered, where the merge uses the entry's value from before the edge.

// File: rtl/pgmap_pkg.sv
package pgmap_pkg;

  // Position of the two-bit page status field inside an entry
  localparam int ST_LO = 13;

  typedef enum logic [1:0] {
    PG_ABSENT = 2'd0,
    PG_CLEAN  = 2'd1,
    PG_READ   = 2'd2,
    PG_DIRTY  = 2'd3
  } pg_state_e;

  // Status after one access; an absent page never changes
  function automatic logic [1:0] next_state(input logic [1:0] cur, input logic wr);
    logic [1:0] res;
    if (cur == PG_ABSENT)     res = cur;
    else if (wr)              res = PG_DIRTY;
    else if (cur == PG_CLEAN) res = PG_READ;
    else                      res = cur;
    return res;
  endfunction

endpackage

// File: rtl/pgmap_xlate.sv
module pgmap_xlate
  import pgmap_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int OFF_W  = 12,
  parameter int IDX_W  = 10,
  parameter int PPN_W  = 10,
  parameter int ENT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_valid,
  input  logic              acc_write,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [ENT_W-1:0]  ent,
  output logic [IDX_W-1:0]  idx,
  output logic [ADDR_W-1:0] phys_addr,
  output logic              upd_en,
  output logic [ENT_W-1:0]  upd_word
);

  localparam int ZONE_LO = OFF_W + IDX_W;
  localparam int PAD_W   = ADDR_W - PPN_W - OFF_W;

  logic       in_zone;
  logic [1:0] cur_st;
  logic [1:0] nxt_st;

  always_comb begin
    in_zone = (acc_addr[ADDR_W-1:ZONE_LO] == '0);
    idx     = acc_addr[ZONE_LO-1:OFF_W];
    if (in_zone)
      phys_addr = {{PAD_W{1'b0}}, ent[PPN_W-1:0], acc_addr[OFF_W-1:0]};
    else
      phys_addr = acc_addr;
  end

  always_comb begin
    cur_st   = ent[ST_LO +: 2];
    nxt_st   = next_state(cur_st, acc_write);
    upd_word = ent;
    upd_word[ST_LO +: 2] = nxt_st;
    upd_en   = acc_valid && in_zone && (nxt_st != cur_st);
  end

  // R1: addresses outside the RAM zone leave unchanged
  assert_passthru_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_addr[ADDR_W-1:ZONE_LO] != '0) |-> (phys_addr == acc_addr));

  // R7: an absent page never requests a table update
  assert_absent_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && (ent[ST_LO +: 2] == PG_ABSENT)) |-> !upd_en);

endmodule

// File: rtl/pgmap_portdec.sv
module pgmap_portdec #(
  parameter int          ADDR_W    = 24,
  parameter int          IDX_W     = 10,
  parameter int          ENT_W     = 16,
  parameter int          WIN_SHIFT = 16,
  parameter logic [7:0]  WIN_TAG   = 8'h40
) (
  input  logic              tbl_wr,
  input  logic              tbl_byte,
  input  logic [ADDR_W-1:0] tbl_addr,
  input  logic [ENT_W-1:0]  tbl_wdata,
  input  logic [ENT_W-1:0]  cur,
  output logic [IDX_W-1:0]  idx,
  output logic              wp_en,
  output logic [ENT_W-1:0]  wp_word
);

  localparam int HB = ENT_W / 2;

  logic win_hit;
  logic unused_alias_bits;

  assign unused_alias_bits = ^tbl_addr[WIN_SHIFT-1:IDX_W+1];

  always_comb begin
    win_hit = (tbl_addr[ADDR_W-1:WIN_SHIFT] == WIN_TAG[ADDR_W-WIN_SHIFT-1:0]);
    idx     = tbl_addr[IDX_W:1];
    wp_en   = tbl_wr && win_hit;
    if (!tbl_byte)
      wp_word = tbl_wdata;
    else if (tbl_addr[0])
      wp_word = {cur[ENT_W-1:HB], tbl_wdata[HB-1:0]};
    else
      wp_word = {tbl_wdata[HB-1:0], cur[HB-1:0]};
  end

endmodule

// File: rtl/pgmap_table.sv
module pgmap_table
  import pgmap_pkg::*;
#(
  parameter int IDX_W = 10,
  parameter int ENT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] ra_idx,
  output logic [ENT_W-1:0] ra_data,
  input  logic [IDX_W-1:0] rb_idx,
  output logic [ENT_W-1:0] rb_data,
  input  logic             wp_en,
  input  logic [IDX_W-1:0] wp_idx,
  input  logic [ENT_W-1:0] wp_word,
  input  logic             up_en,
  input  logic [IDX_W-1:0] up_idx,
  input  logic [ENT_W-1:0] up_word
);

  localparam int DEPTH = 1 << IDX_W;
  localparam logic [ENT_W-1:0] KEEP_M = ~(ENT_W'(2'b11) << ST_LO);

  logic [ENT_W-1:0] mem [DEPTH];
  logic             up_go;
  logic [ENT_W-1:0] up_old;

  always_comb begin
    ra_data = mem[ra_idx];
    rb_data = mem[rb_idx];
    up_old  = mem[up_idx];
    // port write wins over a status update on the same entry
    up_go   = up_en && !(wp_en && (wp_idx == up_idx));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else begin
      if (up_go) mem[up_idx] <= up_word;
      if (wp_en) mem[wp_idx] <= wp_word;
    end
  end

  // R8: a status update keeps every bit outside the status field
  assert_keep_fields_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (up_en && !(wp_en && (wp_idx == up_idx))) |=>
      ((mem[$past(up_idx)] & KEEP_M) == ($past(up_old) & KEEP_M)));

  // R9: on a collision the port value lands in the entry
  assert_port_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wp_en && up_en && (wp_idx == up_idx)) |=> (mem[$past(wp_idx)] == $past(wp_word)));

endmodule

// File: rtl/pgmap_unit.sv
module pgmap_unit #(
  parameter int ADDR_W = 24,
  parameter int OFF_W  = 12,
  parameter int IDX_W  = 10,
  parameter int PPN_W  = 10,
  parameter int ENT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_valid,
  input  logic              acc_write,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic              tbl_wr,
  input  logic              tbl_byte,
  input  logic [ADDR_W-1:0] tbl_addr,
  input  logic [ENT_W-1:0]  tbl_wdata,
  output logic [ADDR_W-1:0] phys_addr,
  output logic [ENT_W-1:0]  tbl_rdata
);

  logic [1:0]       rst_sync;
  logic             rst_s_n;
  logic [IDX_W-1:0] acc_idx;
  logic [ENT_W-1:0] acc_ent;
  logic             upd_en;
  logic [ENT_W-1:0] upd_word;
  logic [IDX_W-1:0] port_idx;
  logic [ENT_W-1:0] port_ent;
  logic             wp_en;
  logic [ENT_W-1:0] wp_word;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_s_n = rst_sync[1];

  pgmap_xlate #(
    .ADDR_W(ADDR_W), .OFF_W(OFF_W), .IDX_W(IDX_W), .PPN_W(PPN_W), .ENT_W(ENT_W)
  ) u_xlate (
    .clk(clk), .rst_n(rst_s_n),
    .acc_valid(acc_valid), .acc_write(acc_write), .acc_addr(acc_addr),
    .ent(acc_ent), .idx(acc_idx), .phys_addr(phys_addr),
    .upd_en(upd_en), .upd_word(upd_word)
  );

  pgmap_portdec #(
    .ADDR_W(ADDR_W), .IDX_W(IDX_W), .ENT_W(ENT_W)
  ) u_portdec (
    .tbl_wr(tbl_wr), .tbl_byte(tbl_byte), .tbl_addr(tbl_addr), .tbl_wdata(tbl_wdata),
    .cur(port_ent), .idx(port_idx), .wp_en(wp_en), .wp_word(wp_word)
  );

  pgmap_table #(
    .IDX_W(IDX_W), .ENT_W(ENT_W)
  ) u_table (
    .clk(clk), .rst_n(rst_s_n),
    .ra_idx(acc_idx), .ra_data(acc_ent),
    .rb_idx(port_idx), .rb_data(port_ent),
    .wp_en(wp_en), .wp_idx(port_idx), .wp_word(wp_word),
    .up_en(upd_en), .up_idx(acc_idx), .up_word(upd_word)
  );

  assign tbl_rdata = port_ent;

endmodule

// File: tb/pgmap_unit_tb.sv
module pgmap_unit_tb;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        acc_valid, acc_write;
  logic [23:0] acc_addr;
  logic        tbl_wr, tbl_byte;
  logic [23:0] tbl_addr;
  logic [15:0] tbl_wdata;
  logic [23:0] phys_addr;
  logic [15:0] tbl_rdata;

  logic [15:0] mdl [1024];
  int nchk = 0;
  int nerr = 0;
  bit done = 0;

  always #4 clk = ~clk;

  pgmap_unit u_dut (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
    .acc_addr(acc_addr), .tbl_wr(tbl_wr), .tbl_byte(tbl_byte), .tbl_addr(tbl_addr),
    .tbl_wdata(tbl_wdata), .phys_addr(phys_addr), .tbl_rdata(tbl_rdata)
  );

  function automatic logic [23:0] exp_phys(input logic [23:0] a);
    if (a < 24'h400000) return {2'b00, mdl[a[21:12]][9:0], a[11:0]};
    return a;
  endfunction

  task automatic check(input string rq, input logic [23:0] act, input logic [23:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic drive(input logic av, input logic aw, input logic [23:0] aa,
                       input logic tw, input logic tb, input logic [23:0] ta,
                       input logic [15:0] td);
    acc_valid = av; acc_write = aw; acc_addr = aa;
    tbl_wr = tw; tbl_byte = tb; tbl_addr = ta; tbl_wdata = td;
  endtask

  // check outputs, then advance one edge while updating the model
  task automatic step(input string rq_rd);
    logic [15:0] upd, tw_word;
    logic        do_upd, do_tw;
    int          ui, ti;
    logic [1:0]  cur, ns;
    #2;
    check((acc_addr < 24'h400000) ? "R2" : "R1", phys_addr, exp_phys(acc_addr));
    check(rq_rd, {8'h00, tbl_rdata}, {8'h00, mdl[tbl_addr[10:1]]});
    ui = int'(acc_addr[21:12]);
    cur = mdl[ui][14:13];
    ns = (cur == 2'd0) ? cur : (acc_write ? 2'd3 : ((cur == 2'd1) ? 2'd2 : cur));
    upd = {mdl[ui][15], ns, mdl[ui][12:0]};
    do_upd = acc_valid && (acc_addr < 24'h400000);
    ti = int'(tbl_addr[10:1]);
    do_tw = tbl_wr && (tbl_addr[23:16] == 8'h40);
    if (!tbl_byte) tw_word = tbl_wdata;
    else if (tbl_addr[0]) tw_word = {mdl[ti][15:8], tbl_wdata[7:0]};
    else tw_word = {tbl_wdata[7:0], mdl[ti][7:0]};
    @(posedge clk);
    if (do_upd) mdl[ui] = upd;
    if (do_tw) mdl[ti] = tw_word;
    @(negedge clk);
  endtask

  task automatic idle_rd(input logic [9:0] i, input string rq);
    drive(1'b0, 1'b0, 24'h800000, 1'b0, 1'b0, {13'h0200, i, 1'b0}, 16'h0);
    step(rq);
  endtask

  task automatic twr(input logic tb, input logic [23:0] ta, input logic [15:0] td, input string rq);
    drive(1'b0, 1'b0, 24'h800000, 1'b1, tb, ta, td);
    step(rq);
  endtask

  task automatic acc(input logic aw, input logic [23:0] aa, input string rq);
    drive(1'b1, aw, aa, 1'b0, 1'b0, {13'h0200, aa[21:12], 1'b0}, 16'h0);
    step(rq);
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      nerr++; nchk++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd24681));
    for (int i = 0; i < 1024; i++) mdl[i] = 16'h0;
    rst_n = 1'b0;
    drive(1'b0, 1'b0, 24'h0, 1'b0, 1'b0, 24'h400000, 16'h0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R10: reset contents
    idle_rd(10'd0, "R10");
    idle_rd(10'd5, "R10");
    idle_rd(10'd1023, "R10");

    // R3: word then byte writes
    twr(1'b0, 24'h40000A, 16'hA155, "R3");
    idle_rd(10'd5, "R3");
    twr(1'b1, 24'h40000B, 16'hFF3C, "R3");
    idle_rd(10'd5, "R3");
    twr(1'b1, 24'h40000A, 16'h00A1, "R3");
    idle_rd(10'd5, "R3");

    // R4: aliasing and out-of-window writes
    twr(1'b0, 24'h40F80A, 16'hA123, "R4");
    idle_rd(10'd5, "R4");
    twr(1'b0, 24'h41000A, 16'h0000, "R4");
    idle_rd(10'd5, "R4");

    // R5 / R2: clean page read then write
    acc(1'b0, 24'h005ABC, "R2");
    idle_rd(10'd5, "R5");
    twr(1'b0, 24'h40000E, 16'h2077, "R5");
    acc(1'b1, 24'h007010, "R2");
    idle_rd(10'd7, "R5");

    // R6: status 2 and 3 transitions
    acc(1'b0, 24'h007FFF, "R6");
    idle_rd(10'd7, "R6");
    twr(1'b0, 24'h400010, 16'hC001, "R6");
    acc(1'b0, 24'h008000, "R6");
    idle_rd(10'd8, "R6");
    acc(1'b1, 24'h008004, "R6");
    idle_rd(10'd8, "R6");

    // R7: absent page
    twr(1'b0, 24'h400012, 16'h9FFF, "R7");
    acc(1'b1, 24'h009000, "R7");
    idle_rd(10'd9, "R7");

    // R8: write-enable bit and frame preserved
    twr(1'b0, 24'h400014, 16'h3FFF, "R8");
    acc(1'b1, 24'h00A000, "R8");
    idle_rd(10'd10, "R8");
    twr(1'b0, 24'h400016, 16'hA2AA, "R8");
    acc(1'b0, 24'h00B000, "R8");
    idle_rd(10'd11, "R8");

    // R9: collision on one entry (word, then byte merge)
    twr(1'b0, 24'h400018, 16'h2005, "R9");
    drive(1'b1, 1'b1, 24'h00C123, 1'b1, 1'b0, 24'h400018, 16'h2111);
    step("R9");
    idle_rd(10'd12, "R9");
    drive(1'b1, 1'b1, 24'h00C000, 1'b1, 1'b1, 24'h400019, 16'h0042);
    step("R9");
    idle_rd(10'd12, "R9");

    // R1: passthrough
    acc(1'b1, 24'h400000, "R1");
    acc(1'b0, 24'hFFFFFF, "R1");

    // random phase on a small page pool
    for (int n = 0; n < 4000; n++) begin
      logic [23:0] aa, ta;
      logic [2:0]  pg;
      pg = 3'($urandom);
      aa = {2'b00, 7'h00, pg, 12'($urandom)};
      if ($urandom % 8 == 0) aa = 24'($urandom) | 24'h400000;
      ta = {8'h40, 4'($urandom), 1'($urandom), 7'h00, 3'($urandom), 1'($urandom)};
      if ($urandom % 10 == 0) ta[23:16] = 8'h41;
      drive(1'($urandom), 1'($urandom), aa, ($urandom % 4 == 0), 1'($urandom), ta, 16'($urandom));
      step("R11");
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

endmodule